// File: doc/BRIEF.md
# RISC Integer Execution Unit

This block is the integer execute stage of a three-operand load/store RISC core. It receives a 32-bit instruction word together with the two register operand values that the register file has already read for it. In the same cycle it returns the value to be written back, the index of the destination register, a write enable and an illegal-instruction flag. The block is purely combinational and holds no state. Register storage, memory access and branch handling are done by neighbouring blocks.

Two instruction layouts are decoded. Register format has a 6-bit opcode in bits 31:26 equal to zero, source index rs in bits 25:21, rt in bits 20:16, destination rd in bits 15:11, shift amount in bits 10:6 and a 6-bit function code in bits 5:0. Immediate format keeps the opcode, rs and rt fields and places a 16-bit constant in bits 15:0. In that layout rt names the destination. The operand port `rs_val` carries the value of register rs, and `rt_val` carries the value of register rt.

The block carries a single operation at a time with no stream handshake. The neighbouring pipeline registers it on every clock, so it has no back-pressure rule of its own.

Top module: `risc_exu`

## Requirements
- R1: With opcode 0, function 32 yields rs_val + rt_val and function 34 yields rs_val - rt_val, both modulo 2^32 with no overflow trap. The destination is rd (bits 15:11).
- R2: With opcode 0, function 36 yields rs_val AND rt_val, function 37 yields rs_val OR rt_val, and function 39 yields NOT(rs_val OR rt_val).
- R3: With opcode 0 and function 42, the result is 1 when rs_val is less than rt_val as signed two's complement numbers, and 0 otherwise.
- R4: With opcode 0, function 0 shifts rt_val left and function 2 shifts rt_val right, both logically, by the amount in bits 10:6. Zeros fill the vacated bits, and rs_val has no effect on the result.
- R5: Opcode 8 yields rs_val plus the sign-extended bits 15:0. Opcode 10 yields 1 when rs_val is less than the sign-extended constant as a signed comparison, and 0 otherwise. For every immediate-format instruction the destination is rt (bits 20:16).
- R6: Opcode 12 yields rs_val AND the zero-extended constant, and opcode 13 yields rs_val OR the zero-extended constant.
- R7: Opcode 15 places bits 15:0 in result bits 31:16 and clears result bits 15:0, whatever the operand values.
- R8: The illegal flag is raised, write enable is low and the result is 0 in three cases: an opcode other than 0, 8, 10, 12, 13 or 15; opcode 0 with a function code outside the set above; or a shift whose rs field (bits 25:21) is not zero.
- R9: When the destination index is 0, write enable is low. The illegal flag and the computed result are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word to execute |
| rs_val | input | 32 | Value of register named by bits 25:21 |
| rt_val | input | 32 | Value of register named by bits 20:16 |
| result | output | 32 | Value to write back |
| dest_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Write back the result |
| illegal | output | 1 | Instruction not recognised |

## Verification
Two conditions can suppress a write in the same cycle: an unrecognised encoding and a destination index of zero. The bench provokes each one alone and then both together. It drives an add whose rd is zero and then an unknown function code whose rd is zero. For each case it judges the illegal flag, the write enable and the result separately. This shows that the zero-destination rule suppresses only the write, while the illegal rule also clears the result. A second overlap is a shift whose rs field is not zero, which has a legal function code but is still illegal.

// File: rtl/risc_exu_pkg.sv
package risc_exu_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;
  localparam int IDX_W = 5;
  localparam int IMM_W = 16;

  localparam logic [OPC_W-1:0] OPC_REG  = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'd8;
  localparam logic [OPC_W-1:0] OPC_SLTI = 6'd10;
  localparam logic [OPC_W-1:0] OPC_ANDI = 6'd12;
  localparam logic [OPC_W-1:0] OPC_ORI  = 6'd13;
  localparam logic [OPC_W-1:0] OPC_LUI  = 6'd15;

  localparam logic [FN_W-1:0] FN_SLL = 6'd0;
  localparam logic [FN_W-1:0] FN_SRL = 6'd2;
  localparam logic [FN_W-1:0] FN_ADD = 6'd32;
  localparam logic [FN_W-1:0] FN_SUB = 6'd34;
  localparam logic [FN_W-1:0] FN_AND = 6'd36;
  localparam logic [FN_W-1:0] FN_OR  = 6'd37;
  localparam logic [FN_W-1:0] FN_NOR = 6'd39;
  localparam logic [FN_W-1:0] FN_SLT = 6'd42;

  typedef enum logic [3:0] {
    XOP_ADD, XOP_SUB, XOP_AND, XOP_OR, XOP_NOR,
    XOP_SLT, XOP_SLL, XOP_SRL, XOP_LUI, XOP_NONE
  } xop_e;

  typedef enum logic [1:0] {
    SRCB_REG, SRCB_SEXT, SRCB_ZEXT
  } srcb_e;

  typedef struct packed {
    xop_e              op;
    srcb_e             srcb;
    logic [IDX_W-1:0]  dst;
    logic              bad;
  } exu_ctl_t;
endpackage

// File: rtl/risc_exu_decode.sv
module risc_exu_decode
  import risc_exu_pkg::*;
(
  input  logic [31:0] instr,
  output exu_ctl_t    ctl
);
  logic [OPC_W-1:0] opc_f;
  logic [FN_W-1:0]  fn_f;
  logic [IDX_W-1:0] rs_f, rt_f, rd_f;

  assign opc_f = instr[31:26];
  assign rs_f  = instr[25:21];
  assign rt_f  = instr[20:16];
  assign rd_f  = instr[15:11];
  assign fn_f  = instr[5:0];

  always_comb begin
    ctl.op   = XOP_NONE;
    ctl.srcb = SRCB_REG;
    ctl.dst  = rt_f;
    ctl.bad  = 1'b0;
    case (opc_f)
      OPC_REG: begin
        ctl.dst = rd_f;
        case (fn_f)
          FN_SLL: begin ctl.op = XOP_SLL; ctl.bad = (rs_f != '0); end
          FN_SRL: begin ctl.op = XOP_SRL; ctl.bad = (rs_f != '0); end
          FN_ADD: ctl.op = XOP_ADD;
          FN_SUB: ctl.op = XOP_SUB;
          FN_AND: ctl.op = XOP_AND;
          FN_OR:  ctl.op = XOP_OR;
          FN_NOR: ctl.op = XOP_NOR;
          FN_SLT: ctl.op = XOP_SLT;
          default: ctl.bad = 1'b1;
        endcase
      end
      OPC_ADDI: begin ctl.op = XOP_ADD; ctl.srcb = SRCB_SEXT; end
      OPC_SLTI: begin ctl.op = XOP_SLT; ctl.srcb = SRCB_SEXT; end
      OPC_ANDI: begin ctl.op = XOP_AND; ctl.srcb = SRCB_ZEXT; end
      OPC_ORI:  begin ctl.op = XOP_OR;  ctl.srcb = SRCB_ZEXT; end
      OPC_LUI:  ctl.op = XOP_LUI;
      default:  ctl.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/risc_exu_shift.sv
module risc_exu_shift #(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  input  logic              to_right,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stage [0:SH_W];

  assign stage[0] = din;

  for (genvar g = 0; g < SH_W; g++) begin : g_stage
    localparam int DIST = 1 << g;
    logic [DATA_W-1:0] moved;
    assign moved = to_right ? (stage[g] >> DIST) : (stage[g] << DIST);
    assign stage[g+1] = amt[g] ? moved : stage[g];
  end

  assign dout = stage[SH_W];
endmodule

// File: rtl/risc_exu_alu.sv
module risc_exu_alu
  import risc_exu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  xop_e              op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] sh_src,
  input  logic [SH_W-1:0]   sh_amt,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] y
);
  logic [DATA_W-1:0] shifted;
  logic              lt;

  risc_exu_shift #(.DATA_W(DATA_W)) shift_i (
    .din      (sh_src),
    .amt      (sh_amt),
    .to_right (op == XOP_SRL),
    .dout     (shifted)
  );

  assign lt = $signed(a) < $signed(b);

  always_comb begin
    case (op)
      XOP_ADD: y = a + b;
      XOP_SUB: y = a - b;
      XOP_AND: y = a & b;
      XOP_OR:  y = a | b;
      XOP_NOR: y = ~(a | b);
      XOP_SLT: y = {{(DATA_W-1){1'b0}}, lt};
      XOP_SLL, XOP_SRL: y = shifted;
      XOP_LUI: y = {imm, {(DATA_W-IMM_W){1'b0}}};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/risc_exu.sv
module risc_exu
  import risc_exu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  output logic [DATA_W-1:0] result,
  output logic [IDX_W-1:0]  dest_idx,
  output logic              wr_en,
  output logic              illegal
);
  exu_ctl_t          ctl;
  logic [IMM_W-1:0]  imm;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] alu_y;

  assign imm = instr[IMM_W-1:0];

  risc_exu_decode dec_i (
    .instr (instr),
    .ctl   (ctl)
  );

  always_comb begin
    case (ctl.srcb)
      SRCB_SEXT: opnd_b = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
      SRCB_ZEXT: opnd_b = {{(DATA_W-IMM_W){1'b0}}, imm};
      default:   opnd_b = rt_val;
    endcase
  end

  risc_exu_alu #(.DATA_W(DATA_W)) alu_i (
    .op     (ctl.op),
    .a      (rs_val),
    .b      (opnd_b),
    .sh_src (rt_val),
    .sh_amt (instr[6 +: SH_W]),
    .imm    (imm),
    .y      (alu_y)
  );

  assign illegal  = ctl.bad;
  assign dest_idx = ctl.dst;
  assign wr_en    = !ctl.bad && (ctl.dst != '0);
  assign result   = ctl.bad ? '0 : alu_y;
endmodule

// File: rtl/risc_exu_chk.sv
module risc_exu_chk #(
  parameter int DATA_W = 32
) (
  input logic [31:0]       instr,
  input logic [DATA_W-1:0] result,
  input logic [4:0]        dest_idx,
  input logic              wr_en,
  input logic              illegal
);
  always_comb begin
    // R8
    illegal_no_write_chk: assert (!(illegal && wr_en))
      else $error("write enabled on illegal instruction");
    // R8
    illegal_zero_result_chk: assert (!illegal || result == '0)
      else $error("illegal instruction produced a nonzero result");
    // R9
    zero_dest_no_write_chk: assert (!(dest_idx == 5'd0 && wr_en))
      else $error("write enabled to register zero");
    // R1
    reg_dest_chk: assert (instr[31:26] != 6'd0 || dest_idx == instr[15:11])
      else $error("register format destination mismatch");
    // R5
    imm_dest_chk: assert (instr[31:26] == 6'd0 || dest_idx == instr[20:16])
      else $error("immediate format destination mismatch");
    // R3
    slt_bool_chk: assert (!(instr[31:26] == 6'd0 && instr[5:0] == 6'd42) || result[DATA_W-1:1] == '0)
      else $error("compare result not 0 or 1");
    // R7
    upper_low_clear_chk: assert (instr[31:26] != 6'd15 || result[15:0] == 16'd0)
      else $error("upper immediate low half not clear");
  end
endmodule

bind risc_exu risc_exu_chk #(.DATA_W(DATA_W)) chk_i (
  .instr    (instr),
  .result   (result),
  .dest_idx (dest_idx),
  .wr_en    (wr_en),
  .illegal  (illegal)
);

// File: tb/risc_exu_tb_top.sv
module risc_exu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [31:0] result;
  logic [4:0]  dest_idx;
  logic        wr_en;
  logic        illegal;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  risc_exu dut_i (
    .instr    (instr),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .result   (result),
    .dest_idx (dest_idx),
    .wr_en    (wr_en),
    .illegal  (illegal)
  );

  function automatic logic [31:0] rfmt(input logic [4:0] rs, input logic [4:0] rt,
                                       input logic [4:0] rd, input logic [4:0] sh,
                                       input logic [5:0] fn);
    return {6'd0, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] ifmt(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] k);
    return {op, rs, rt, k};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    instr = i; rs_val = a; rt_val = b;
    #1;
  endtask

  task automatic t_reset;
    run(32'd0, 32'd0, 32'd0);
    chk("R9", "reset wr_en", {31'd0, wr_en}, 32'd0);
    chk("R9", "reset illegal", {31'd0, illegal}, 32'd0);
    chk("R4", "reset result", result, 32'd0);
  endtask

  task automatic t_addsub;
    run(rfmt(5'd1, 5'd2, 5'd9, 5'd0, 6'd32), 32'd7, 32'd5);
    chk("R1", "add", result, 32'd12);
    chk("R1", "add dest", {27'd0, dest_idx}, 32'd9);
    chk("R1", "add wr_en", {31'd0, wr_en}, 32'd1);
    run(rfmt(5'd1, 5'd2, 5'd9, 5'd0, 6'd32), 32'hFFFF_FFFF, 32'd1);
    chk("R1", "add wrap", result, 32'd0);
    run(rfmt(5'd1, 5'd2, 5'd3, 5'd0, 6'd34), 32'd5, 32'd7);
    chk("R1", "sub", result, 32'hFFFF_FFFE);
  endtask

  task automatic t_logic;
    run(rfmt(5'd1, 5'd2, 5'd4, 5'd0, 6'd36), 32'hF0F0_1234, 32'h0FF0_FF00);
    chk("R2", "and", result, 32'h00F0_1200);
    run(rfmt(5'd1, 5'd2, 5'd4, 5'd0, 6'd37), 32'hF0F0_1234, 32'h0FF0_FF00);
    chk("R2", "or", result, 32'hFFF0_FF34);
    run(rfmt(5'd1, 5'd2, 5'd4, 5'd0, 6'd39), 32'hF0F0_1234, 32'h0FF0_FF00);
    chk("R2", "nor", result, 32'h000F_00CB);
  endtask

  task automatic t_slt;
    run(rfmt(5'd1, 5'd2, 5'd5, 5'd0, 6'd42), 32'hFFFF_FFFF, 32'd1);
    chk("R3", "slt neg<pos", result, 32'd1);
    run(rfmt(5'd1, 5'd2, 5'd5, 5'd0, 6'd42), 32'd1, 32'hFFFF_FFFF);
    chk("R3", "slt pos<neg", result, 32'd0);
    run(rfmt(5'd1, 5'd2, 5'd5, 5'd0, 6'd42), 32'd77, 32'd77);
    chk("R3", "slt equal", result, 32'd0);
  endtask

  task automatic t_shift;
    run(rfmt(5'd0, 5'd2, 5'd6, 5'd31, 6'd0), 32'hDEAD_BEEF, 32'd1);
    chk("R4", "sll 31", result, 32'h8000_0000);
    run(rfmt(5'd0, 5'd2, 5'd6, 5'd4, 6'd2), 32'hDEAD_BEEF, 32'h8000_0000);
    chk("R4", "srl zero fill", result, 32'h0800_0000);
    run(rfmt(5'd0, 5'd2, 5'd6, 5'd0, 6'd2), 32'h1234_5678, 32'hCAFE_F00D);
    chk("R4", "srl 0", result, 32'hCAFE_F00D);
    run(rfmt(5'd3, 5'd2, 5'd6, 5'd1, 6'd0), 32'd0, 32'd1);
    chk("R8", "shift rs field set illegal", {31'd0, illegal}, 32'd1);
    chk("R8", "shift rs field set result", result, 32'd0);
  endtask

  task automatic t_imm;
    run(ifmt(6'd8, 5'd1, 5'd12, 16'hFFFF), 32'd10, 32'hAAAA_AAAA);
    chk("R5", "addi", result, 32'd9);
    chk("R5", "addi dest", {27'd0, dest_idx}, 32'd12);
    run(ifmt(6'd10, 5'd1, 5'd12, 16'hFFFE), 32'hFFFF_FFFB, 32'd0);
    chk("R5", "slti -5<-2", result, 32'd1);
    run(ifmt(6'd10, 5'd1, 5'd12, 16'h8000), 32'd3, 32'd0);
    chk("R5", "slti 3<-32768", result, 32'd0);
    run(ifmt(6'd12, 5'd1, 5'd7, 16'h8001), 32'hFFFF_FFFF, 32'd0);
    chk("R6", "andi zext", result, 32'h0000_8001);
    run(ifmt(6'd13, 5'd1, 5'd7, 16'hFFFF), 32'h1234_0000, 32'd0);
    chk("R6", "ori zext", result, 32'h1234_FFFF);
    run(ifmt(6'd15, 5'd1, 5'd8, 16'hAAAA), 32'h5555_5555, 32'h3333_3333);
    chk("R7", "lui", result, 32'hAAAA_0000);
    chk("R7", "lui wr_en", {31'd0, wr_en}, 32'd1);
  endtask

  task automatic t_illegal;
    run(ifmt(6'h3F, 5'd1, 5'd2, 16'h1234), 32'd1, 32'd2);
    chk("R8", "bad opcode illegal", {31'd0, illegal}, 32'd1);
    chk("R8", "bad opcode wr_en", {31'd0, wr_en}, 32'd0);
    chk("R8", "bad opcode result", result, 32'd0);
    run(rfmt(5'd1, 5'd2, 5'd3, 5'd0, 6'd1), 32'd1, 32'd2);
    chk("R8", "bad funct illegal", {31'd0, illegal}, 32'd1);
    chk("R8", "bad funct wr_en", {31'd0, wr_en}, 32'd0);
  endtask

  task automatic t_zero_dest;
    run(rfmt(5'd1, 5'd2, 5'd0, 5'd0, 6'd32), 32'd7, 32'd5);
    chk("R9", "rd0 wr_en", {31'd0, wr_en}, 32'd0);
    chk("R9", "rd0 illegal", {31'd0, illegal}, 32'd0);
    chk("R9", "rd0 result", result, 32'd12);
    run(ifmt(6'd8, 5'd1, 5'd0, 16'd3), 32'd4, 32'd0);
    chk("R9", "rt0 wr_en", {31'd0, wr_en}, 32'd0);
    run(rfmt(5'd1, 5'd2, 5'd0, 5'd0, 6'd50), 32'd7, 32'd5);
    chk("R9", "rd0 bad illegal", {31'd0, illegal}, 32'd1);
    chk("R8", "rd0 bad result", result, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_addsub();
    t_logic();
    t_slt();
    t_shift();
    t_imm();
    t_illegal();
    t_zero_dest();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule